// File: doc/BRIEF.md
# AES Key Schedule Step Unit

This unit carries out one step of AES-128 key expansion as two separate register-to-register operations. The round step takes the upper 32-bit word of `in_rs1` and a 4-bit round number. It rotates the word, passes each byte through the forward AES substitution box and folds in the round constant. The resulting word is written to both halves of the 64-bit result. The chain step takes two 64-bit operands and produces two running XOR words. Software alternates the two operations to build each round key. The register file, instruction decode and the loop over rounds lie outside this unit.

Operands enter on a valid/ready handshake. A transfer happens on any rising edge where `in_valid` and `in_ready` are both high. The result sits in a single output register and is offered with `out_valid`. While `out_valid` is high and `out_ready` is low, the register holds its contents and `in_ready` stays low. The upstream source must then keep its operands until the transfer is taken. When `out_ready` is high, a new operand set can be accepted on every cycle.

Top module: `aes_kstep_unit`

## Requirements
- R1: Round step (`in_op`=0) with `in_rnum` 0..9: the working word w = `in_rs1[63:32]` is rotated right by 8 bits. Each byte then goes through the forward AES S-box and stays in its lane. After that, the round constant is XORed into bits [7:0].
- R2: The round constants for `in_rnum` 0,1,...,9 are 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B, 0x36 in that order (repeated doubling in GF(2^8) modulo 0x11B).
- R3: With `in_rnum`=0xA (the final round), w is substituted byte by byte with no rotation and no round constant.
- R4: The 32-bit word of a round step appears in both `out_result[31:0]` and `out_result[63:32]`.
- R5: A round step with `in_rnum` 0xB..0xF gives `out_result`=0 with `out_illegal`=1. `out_illegal` is 0 for every other accepted operation.
- R6: Chain step (`in_op`=1): with lo = `in_rs1[63:32]` ^ `in_rs2[31:0]`, `out_result[31:0]` = lo and `out_result[63:32]` = lo ^ `in_rs2[63:32]`. `in_rnum` has no effect on it.
- R7: The result of a transfer accepted at one rising edge is present with `out_valid`=1 after that edge. If nothing is accepted while `out_ready` is high, `out_valid` drops at the next edge.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_result` and `out_illegal` hold steady. `in_ready` = !`out_valid` | `out_ready`.
- R9: After reset, `out_valid`, `out_result` and `out_illegal` are all zero.
- R10: A round step ignores `in_rs1[31:0]` and `in_rs2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_op | input | 1 | 0 = round step, 1 = chain step |
| in_rs1 | input | 64 | First operand |
| in_rs2 | input | 64 | Second operand (chain step only) |
| in_rnum | input | 4 | Round number (round step only) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 64 | Registered result |
| out_illegal | output | 1 | Round number was out of range |

## Verification
The properties take it that, once the upstream offers an operand set, it keeps that set unchanged until the transfer is taken. They also take it that `in_op` and `in_rnum` are driven to known values on every cycle in which `in_valid` is high. The stimulus keeps within these limits by changing inputs only on the falling edge. During the stall test it holds the refused operand set unchanged for the whole time `out_ready` is low. It sweeps every round-number code with random operands and compares the results against an S-box that the bench builds by a different arithmetic route from the one the design uses.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  localparam int unsigned RNUM_W = 4;
  localparam logic [RNUM_W-1:0] RNUM_FINAL = 4'hA;

  typedef enum logic {
    KS_OP_ROUND = 1'b0,
    KS_OP_CHAIN = 1'b1
  } ks_op_e;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // forward S-box: inverse as x^254, then the affine map
  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] pw;
    inv = 8'h01;
    pw  = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) inv = gf_mul(inv, pw);
      pw = gf_mul(pw, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  // round constant: 0x01 doubled rnum times
  function automatic logic [7:0] round_const(input logic [RNUM_W-1:0] rnum);
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 0; i < 10; i++) begin
      if (i < int'(rnum)) rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
    end
    return rc;
  endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox
  import aes_ks_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  assign byte_o = sbox_fwd(byte_i);
endmodule

// File: rtl/aes_ks_round_word.sv
module aes_ks_round_word
  import aes_ks_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0] word_i,
  input  logic [RNUM_W-1:0] rnum_i,
  output logic [HALF_W-1:0] word_o,
  output logic              illegal_o
);
  localparam int LANES = HALF_W / 8;

  logic              is_final;
  logic              is_round;
  logic [HALF_W-1:0] rot_w;
  logic [HALF_W-1:0] sub_w;

  assign is_final = (rnum_i == RNUM_FINAL);
  assign is_round = (rnum_i < RNUM_FINAL);
  assign rot_w    = is_final ? word_i : {word_i[7:0], word_i[HALF_W-1:8]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aes_ks_sbox lane_i (
      .byte_i(rot_w[g*8 +: 8]),
      .byte_o(sub_w[g*8 +: 8])
    );
  end

  always_comb begin
    illegal_o = !(is_final || is_round);
    word_o    = sub_w;
    if (is_round) word_o[7:0] = sub_w[7:0] ^ round_const(rnum_i);
    if (illegal_o) word_o = '0;
  end
endmodule

// File: rtl/aes_ks_chain.sv
module aes_ks_chain #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0] a_hi_i,
  input  logic [HALF_W-1:0] b_lo_i,
  input  logic [HALF_W-1:0] b_hi_i,
  output logic [2*HALF_W-1:0] word_o
);
  logic [HALF_W-1:0] lo_w;
  assign lo_w   = a_hi_i ^ b_lo_i;
  assign word_o = {lo_w ^ b_hi_i, lo_w};
endmodule

// File: rtl/aes_kstep_unit.sv
module aes_kstep_unit
  import aes_ks_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [DATA_W-1:0] in_rs1,
  input  logic [DATA_W-1:0] in_rs2,
  input  logic [RNUM_W-1:0] in_rnum,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] round_w;
  logic              round_ill;
  logic [DATA_W-1:0] chain_w;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_illegal;
  logic              accept;

  aes_ks_round_word #(.HALF_W(HALF_W)) round_i (
    .word_i   (in_rs1[DATA_W-1:HALF_W]),
    .rnum_i   (in_rnum),
    .word_o   (round_w),
    .illegal_o(round_ill)
  );

  aes_ks_chain #(.HALF_W(HALF_W)) chain_i (
    .a_hi_i(in_rs1[DATA_W-1:HALF_W]),
    .b_lo_i(in_rs2[HALF_W-1:0]),
    .b_hi_i(in_rs2[DATA_W-1:HALF_W]),
    .word_o(chain_w)
  );

  always_comb begin
    if (ks_op_e'(in_op) == KS_OP_CHAIN) begin
      nxt_result  = chain_w;
      nxt_illegal = 1'b0;
    end else begin
      nxt_result  = {round_w, round_w};
      nxt_illegal = round_ill;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nxt_result;
      out_illegal <= nxt_illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/aes_kstep_unit_chk.sv
module aes_kstep_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_op,
  input logic [DATA_W/2-1:0] in_rs1_hi,
  input logic [DATA_W-1:0] in_rs2,
  input logic [3:0]        in_rnum,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);
  localparam int HALF_W = DATA_W / 2;
  logic take;
  assign take = in_valid && in_ready;

  assert_accept_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  assert_halves_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_op) |=> (out_result[HALF_W-1:0] == out_result[DATA_W-1:HALF_W]));

  assert_bad_rnum_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_op && in_rnum > 4'hA) |=> out_illegal);

  assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0));

  assert_chain_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op) |=> (!out_illegal &&
      out_result[HALF_W-1:0] == ($past(in_rs1_hi) ^ $past(in_rs2[HALF_W-1:0]))));
endmodule

bind aes_kstep_unit aes_kstep_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_rs1_hi  (in_rs1[DATA_W-1:DATA_W/2]),
  .in_rs2     (in_rs2),
  .in_rnum    (in_rnum),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_illegal(out_illegal)
);

// File: tb/aes_kstep_unit_tb.sv
module aes_kstep_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_op = 1'b0;
  logic [63:0] in_rs1 = '0;
  logic [63:0] in_rs2 = '0;
  logic [3:0]  in_rnum = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] sb [256];
  logic [7:0] rc [10];

  always #5 clk = ~clk;

  aes_kstep_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rnum(in_rnum),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic logic [7:0] rl8(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  // table built by stepping generator 3 and its inverse
  task automatic build_tables();
    logic [7:0] p = 8'h01;
    logic [7:0] q = 8'h01;
    logic [7:0] r = 8'h01;
    for (int n = 0; n < 255; n++) begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl8(q, 1) ^ rl8(q, 2) ^ rl8(q, 3) ^ rl8(q, 4) ^ 8'h63;
    end
    sb[0] = 8'h63;
    for (int i = 0; i < 10; i++) begin
      rc[i] = r;
      r = (r << 1) ^ (r[7] ? 8'h1b : 8'h00);
    end
  endtask

  function automatic logic [64:0] model_round(input logic [63:0] a, input logic [3:0] rn);
    logic [31:0] w = a[63:32];
    logic [31:0] s;
    if (rn > 4'hA) return {1'b1, 64'h0};
    if (rn != 4'hA) w = {w[7:0], w[31:8]};
    s = {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    if (rn < 4'hA) s[7:0] = s[7:0] ^ rc[rn];
    return {1'b0, s, s};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic gi,
                       input logic [63:0] exp, input logic ei);
    n_cmp++;
    if (got !== exp || gi !== ei) begin
      n_bad++;
      $display("FAIL %s: result=%h illegal=%b expected %h illegal=%b", tag, got, gi, exp, ei);
    end
  endtask

  task automatic run_op(input string tag, input logic op, input logic [63:0] a,
                        input logic [63:0] b, input logic [3:0] rn,
                        input logic [64:0] exp);
    @(negedge clk);
    in_op = op; in_rs1 = a; in_rs2 = b; in_rnum = rn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid"}, {63'h0, out_valid}, 1'b0, 64'h1, 1'b0);
    check(tag, out_result, out_illegal, exp[63:0], exp[64]);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, hold_res;
    logic [31:0] lo;
    build_tables();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset state", out_result, out_illegal, 64'h0, 1'b0);
    check("R9 reset valid", {63'h0, out_valid}, 1'b0, 64'h0, 1'b0);
    rst_n = 1'b1;

    // fixed points of the S-box and round constant
    run_op("R3 final zero word", 1'b0, 64'h0, 64'h0, 4'hA, {1'b0, 64'h6363636363636363});
    run_op("R3 final 0x53 lane", 1'b0, 64'h00000053_ffffffff, 64'h0, 4'hA,
           {1'b0, 64'h636363ed636363ed});
    run_op("R2 rnum0 zero word", 1'b0, 64'h0, 64'h0, 4'h0, {1'b0, 64'h6363636263636362});
    run_op("R1 rotate 01 to top", 1'b0, 64'h00000001_00000000, 64'h0, 4'h1,
           {1'b0, 64'h7c636361_7c636361});

    // sweep every round-number code
    for (int rn = 0; rn < 16; rn++) begin
      for (int k = 0; k < 8; k++) begin
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        run_op(rn > 10 ? "R5 illegal rnum" : (rn == 10 ? "R3 final sweep" : "R1 R2 R4 round sweep"),
               1'b0, a, b, 4'(rn), model_round(a, 4'(rn)));
      end
    end

    // low half of rs1 and rs2 have no effect on the round step
    a = {$urandom, $urandom};
    run_op("R10 low rs1 variant A", 1'b0, a, 64'h0, 4'h3, model_round(a, 4'h3));
    run_op("R10 low rs1 variant B", 1'b0, {a[63:32], ~a[31:0]}, 64'hffffffff_ffffffff, 4'h3,
           model_round(a, 4'h3));

    // chain step with random rnum
    for (int k = 0; k < 32; k++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      lo = a[63:32] ^ b[31:0];
      run_op("R6 chain", 1'b1, a, b, 4'($urandom), {1'b0, lo ^ b[63:32], lo});
    end

    // R7: output drops when nothing new arrives
    @(negedge clk);
    check("R7 idle drop", {63'h0, out_valid}, 1'b0, 64'h0, 1'b0);

    // R8 stall: hold out_ready low, second offer must wait
    out_ready = 1'b0;
    a = 64'h01234567_89abcdef;
    run_op("R8 first under stall", 1'b0, a, 64'h0, 4'h5, model_round(a, 4'h5));
    hold_res = out_result;
    @(negedge clk);
    in_op = 1'b1; in_rs1 = 64'hffff0000_ffff0000; in_rs2 = 64'h12345678_9abcdef0;
    in_valid = 1'b1;
    check("R8 in_ready low", {63'h0, in_ready}, 1'b0, 64'h0, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 held result", out_result, out_illegal, hold_res, 1'b0);
    check("R8 still valid", {63'h0, out_valid}, 1'b0, 64'h1, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lo = 32'hffff0000 ^ 32'h9abcdef0;
    check("R8 R7 queued chain", out_result, out_illegal, {lo ^ 32'h12345678, lo}, 1'b0);
    @(negedge clk);
    check("R7 drained", {63'h0, out_valid}, 1'b0, 64'h0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule